// File: doc/BRIEF.md
# Dual-Timer Raw Interrupt Status

This block gathers the events of two sub-timers, A (index 0) and B (index 1), into one 32-bit raw status word. Each sub-timer can raise five events: counter limit reached (time-out), counter equal to its match value (match), counter and prescaler equal to match and prescale-match while capturing (capture match), a capture edge (capture event), and end of a DMA transfer. An event sets its status bit only when the sub-timer's mode allows it, and the match event also needs its enable.

Status bits are sticky. Software clears them with a write-one-to-clear strobe. The block drives the registered status word and a registered OR of all its bits. The counters, the masking into an interrupt line and the bus access sit outside this block.

The mode field is two bits wide. 0 is one-shot, 1 is periodic, 2 is input edge-time and 3 is input edge-count.

Top module: `dual_tmr_ris`

## Requirements
- R1: While `rst` is high at a clock edge, `ris` and `ris_any` become 0 after that edge, whatever the event inputs are.
- R2: In mode 0 or 1 with `tm_up`=0, a counter value of 0 sets the time-out bit. The time-out bit is bit 0 for A and bit 8 for B.
- R3: In mode 0 or 1 with `tm_up`=1, a counter value equal to `tm_load` sets the time-out bit, and a counter value of 0 does not.
- R4: In mode 2 or 3 the time-out bit and the match bit are never set.
- R5: In mode 0 or 1 with `tm_mie`=1 and `tm_pm_en`=0, a counter value equal to `tm_match` sets the match bit. The match bit is bit 4 for A and bit 11 for B. With `tm_mie`=0 the match bit is not set.
- R6: With `tm_pm_en`=1, the match bit also needs `tm_pre` equal to `tm_pmatch`.
- R7: In mode 2, a high `tm_cap` sets the capture-event bit (bit 2 for A, bit 10 for B). In any other mode `tm_cap` has no effect.
- R8: In mode 2, the capture-match bit (bit 1 for A, bit 9 for B) sets when both `tm_cnt`==`tm_match` and `tm_pre`==`tm_pmatch`.
- R9: A high `tm_dma` sets the DMA-done bit in any mode. The DMA-done bit is bit 5 for A and bit 13 for B.
- R10: A set bit stays set until a cycle in which `clr_we` is high and that bit of `clr_mask` is 1. A 0 in `clr_mask` leaves its bit unchanged.
- R11: When a set event and a clear hit the same bit in the same cycle, the bit ends up set.
- R12: Bits 3, 6, 7, 12 and 31..14 of `ris` are always 0.
- R13: `ris_any` equals the OR of all bits of `ris` in every cycle.

An event is seen at the clock edge that samples it. The status bit and `ris_any` show it in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tm_cnt | input | 2 x CW | Counter value for each sub-timer |
| tm_pre | input | 2 x PW | Prescaler value for each sub-timer |
| tm_match | input | 2 x CW | Match value |
| tm_pmatch | input | 2 x PW | Prescale-match value |
| tm_load | input | 2 x CW | Interval-load value, the limit when counting up |
| tm_up | input | 2 | Count direction, 1 = up |
| tm_mode | input | 2 x 2 | Mode: 0 one-shot, 1 periodic, 2 edge-time, 3 edge-count |
| tm_mie | input | 2 | Match event enable |
| tm_pm_en | input | 2 | Include the prescaler in the match compare |
| tm_cap | input | 2 | Capture edge pulse |
| tm_dma | input | 2 | DMA transfer complete pulse |
| clr_we | input | 1 | Clear strobe |
| clr_mask | input | 32 | Bits to clear, 1 = clear |
| ris | output | 32 | Registered raw status word |
| ris_any | output | 1 | Registered OR of all status bits |

## Verification
The assertions assume that `clr_mask` is only looked at while `clr_we` is high. They also assume a mode value outside one-shot and periodic must never raise a time-out, and a mode other than edge-time must never raise a capture event. The bench drives only the four legal mode codes and changes inputs half a period away from the sampling edge.

Most of the run is a sweep. Every cycle it clears all bits while it applies new events, so `ris` should equal exactly that cycle's event set. This keeps every sweep step inside the set-wins-over-clear rule. Short directed runs then cover stickiness and partial clears, with the event inputs held in edge-count mode so that nothing sets by accident.

// File: rtl/tris_pkg.sv
package tris_pkg;

  typedef enum logic [1:0] {
    TM_ONESHOT   = 2'd0,
    TM_PERIODIC  = 2'd1,
    TM_EDGE_TIME = 2'd2,
    TM_EDGE_CNT  = 2'd3
  } tm_mode_e;

  typedef struct packed {
    logic dma;
    logic tmatch;
    logic cevent;
    logic cmatch;
    logic tout;
  } tmr_evt_t;

  localparam int unsigned NTMR    = 2;
  localparam int unsigned RIS_W   = 32;
  localparam int unsigned T_SPAN  = 8;

  // implemented status bits; everything else is tied to zero
  localparam logic [RIS_W-1:0] USED_MASK = 32'h0000_2F37;

  // match bit does not follow the per-timer stride
  function automatic int unsigned match_pos(int unsigned idx);
    return (idx == 0) ? 4 : 11;
  endfunction

  function automatic logic [RIS_W-1:0] place_evt(tmr_evt_t e, int unsigned idx);
    logic [RIS_W-1:0] v;
    int unsigned base;
    v    = '0;
    base = idx * T_SPAN;
    v[base + 0]       = e.tout;
    v[base + 1]       = e.cmatch;
    v[base + 2]       = e.cevent;
    v[match_pos(idx)] = e.tmatch;
    v[base + 5]       = e.dma;
    return v;
  endfunction

endpackage

// File: rtl/tris_evt_detect.sv
module tris_evt_detect
  import tris_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic [CW-1:0] cnt,
  input  logic [PW-1:0] pre,
  input  logic [CW-1:0] mval,
  input  logic [PW-1:0] pmval,
  input  logic [CW-1:0] load,
  input  logic          up,
  input  logic [1:0]    mode,
  input  logic          mie,
  input  logic          pm_en,
  input  logic          cap,
  input  logic          dma,
  output tmr_evt_t      evt
);

  tm_mode_e      md;
  logic          counting;
  logic          edge_time;
  logic [CW-1:0] limit;
  logic          cnt_eq;
  logic          pre_eq;

  always_comb begin
    md        = tm_mode_e'(mode);
    counting  = (md == TM_ONESHOT) || (md == TM_PERIODIC);
    edge_time = (md == TM_EDGE_TIME);
    limit     = up ? load : '0;
    cnt_eq    = (cnt == mval);
    pre_eq    = (pre == pmval);

    evt.tout   = counting && (cnt == limit);
    evt.tmatch = counting && mie && cnt_eq && (!pm_en || pre_eq);
    evt.cevent = edge_time && cap;
    evt.cmatch = edge_time && cnt_eq && pre_eq;
    evt.dma    = dma;
  end

endmodule

// File: rtl/tris_status_reg.sv
module tris_status_reg #(
  parameter int              W    = 32,
  parameter logic [W-1:0]    KEEP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         clr_we,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] stat,
  output logic         any
);

  logic [W-1:0] clr_eff;
  logic [W-1:0] nxt;

  always_comb begin
    clr_eff = clr_we ? clr_vec : '0;
    // set is ORed after the clear so a simultaneous event survives
    nxt     = ((stat & ~clr_eff) | set_vec) & KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      any  <= 1'b0;
    end else begin
      stat <= nxt;
      any  <= |nxt;
    end
  end

endmodule

// File: rtl/dual_tmr_ris.sv
module dual_tmr_ris
  import tris_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0][CW-1:0]   tm_cnt,
  input  logic [1:0][PW-1:0]   tm_pre,
  input  logic [1:0][CW-1:0]   tm_match,
  input  logic [1:0][PW-1:0]   tm_pmatch,
  input  logic [1:0][CW-1:0]   tm_load,
  input  logic [1:0]           tm_up,
  input  logic [1:0][1:0]      tm_mode,
  input  logic [1:0]           tm_mie,
  input  logic [1:0]           tm_pm_en,
  input  logic [1:0]           tm_cap,
  input  logic [1:0]           tm_dma,
  input  logic                 clr_we,
  input  logic [31:0]          clr_mask,
  output logic [31:0]          ris,
  output logic                 ris_any
);

  tmr_evt_t [NTMR-1:0]   evt;
  logic     [RIS_W-1:0]  set_vec;

  for (genvar t = 0; t < NTMR; t++) begin : g_tmr
    tris_evt_detect #(.CW(CW), .PW(PW)) u_det (
      .cnt   (tm_cnt[t]),
      .pre   (tm_pre[t]),
      .mval  (tm_match[t]),
      .pmval (tm_pmatch[t]),
      .load  (tm_load[t]),
      .up    (tm_up[t]),
      .mode  (tm_mode[t]),
      .mie   (tm_mie[t]),
      .pm_en (tm_pm_en[t]),
      .cap   (tm_cap[t]),
      .dma   (tm_dma[t]),
      .evt   (evt[t])
    );
  end

  always_comb begin
    set_vec = '0;
    for (int t = 0; t < NTMR; t++) begin
      set_vec = set_vec | place_evt(evt[t], t);
    end
  end

  tris_status_reg #(.W(RIS_W), .KEEP(USED_MASK)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_we  (clr_we),
    .clr_vec (clr_mask),
    .stat    (ris),
    .any     (ris_any)
  );

endmodule

// File: rtl/tris_chk.sv
module tris_chk
  import tris_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [1:0][1:0] tm_mode,
  input logic [1:0]      tm_cap,
  input logic [1:0]      tm_dma,
  input logic            clr_we,
  input logic [31:0]     clr_mask,
  input logic [31:0]     ris,
  input logic            ris_any
);

  logic [31:0] clr_eff;
  assign clr_eff = clr_we ? clr_mask : 32'h0;

  p_reserved_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (ris & ~USED_MASK) == 32'h0);

  p_any_or_r13: assert property (@(posedge clk) disable iff (rst)
    ris_any == (|ris));

  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(ris) & ~$past(clr_eff) & ~ris) == 32'h0));

  p_clear_dma_a_r10: assert property (@(posedge clk) disable iff (rst)
    (clr_we && clr_mask[5] && !tm_dma[0]) |=> !ris[5]);

  p_dma_set_r9: assert property (@(posedge clk) disable iff (rst)
    tm_dma[1] |=> ris[13]);

  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (tm_dma[0] && clr_we && clr_mask[5]) |=> ris[5]);

  p_cap_evt_r7: assert property (@(posedge clk) disable iff (rst)
    (tm_cap[0] && tm_mode[0] == TM_EDGE_TIME) |=> ris[2]);

  p_cap_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (tm_mode[1] != TM_EDGE_TIME && !ris[10]) |=> !ris[10]);

  p_tout_mode_r4: assert property (@(posedge clk) disable iff (rst)
    ((tm_mode[0] == TM_EDGE_TIME || tm_mode[0] == TM_EDGE_CNT) && !ris[0]) |=> !ris[0]);

endmodule

bind dual_tmr_ris tris_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tm_mode  (tm_mode),
  .tm_cap   (tm_cap),
  .tm_dma   (tm_dma),
  .clr_we   (clr_we),
  .clr_mask (clr_mask),
  .ris      (ris),
  .ris_any  (ris_any)
);

// File: tb/sim_dual_tmr_ris.sv
module sim_dual_tmr_ris;

  localparam int CW = 4;
  localparam int PW = 2;

  logic                clk = 1'b0;
  logic                rst;
  logic [1:0][CW-1:0]  tm_cnt, tm_match, tm_load;
  logic [1:0][PW-1:0]  tm_pre, tm_pmatch;
  logic [1:0]          tm_up, tm_mie, tm_pm_en, tm_cap, tm_dma;
  logic [1:0][1:0]     tm_mode;
  logic                clr_we;
  logic [31:0]         clr_mask;
  logic [31:0]         ris;
  logic                ris_any;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  dual_tmr_ris #(.CW(CW), .PW(PW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_set(int base, int mpos, logic [1:0] md, logic up,
      logic mie, logic pe, logic [CW-1:0] c, logic [PW-1:0] p, logic [CW-1:0] mv,
      logic [PW-1:0] pmv, logic [CW-1:0] ld, logic cap, logic dma);
    logic [31:0] r;
    logic cnting, et;
    r = 32'h0;
    cnting = (md == 2'd0) || (md == 2'd1);
    et     = (md == 2'd2);
    r[base+0] = cnting && (up ? (c == ld) : (c == 0));
    r[base+1] = et && (c == mv) && (p == pmv);
    r[base+2] = et && cap;
    r[mpos]   = cnting && mie && (c == mv) && (!pe || (p == pmv));
    r[base+5] = dma;
    return r;
  endfunction

  task automatic idle_inputs();
    tm_mode  = {2'd3, 2'd3};
    tm_cap   = 2'b00;
    tm_dma   = 2'b00;
    clr_we   = 1'b0;
    clr_mask = 32'h0;
  endtask

  task automatic cyc();
    @(posedge clk);
    #5;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] e;
    int k;
    tm_cnt = '0; tm_pre = '0; tm_up = '0; tm_mie = '0; tm_pm_en = '0;
    tm_match  = {4'd10, 4'd5};
    tm_pmatch = {2'd1, 2'd2};
    tm_load   = {4'd12, 4'd9};
    idle_inputs();
    rst = 1'b1;
    tm_dma = 2'b11;
    @(negedge clk);
    cyc();
    // R1: reset dominates active events
    chk(ris == 32'h0 && !ris_any, "R1", ris, 32'h0);
    @(negedge clk);
    tm_dma = 2'b00;
    rst = 1'b0;
    cyc();
    chk(ris == 32'h0, "R1", ris, 32'h0);

    // sweep: clear all each cycle while applying new events -> ris == event set
    k = 0;
    for (int m = 0; m < 4; m++)
      for (int u = 0; u < 2; u++)
        for (int mi = 0; mi < 2; mi++)
          for (int pe = 0; pe < 2; pe++)
            for (int c = 0; c < 16; c++)
              for (int p = 0; p < 4; p++) begin
                @(negedge clk);
                tm_mode[0]  = 2'(m);
                tm_up[0]    = 1'(u);
                tm_mie[0]   = 1'(mi);
                tm_pm_en[0] = 1'(pe);
                tm_cnt[0]   = 4'(c);
                tm_pre[0]   = 2'(p);
                tm_cap[0]   = 1'(k ^ (k >> 3));
                tm_dma[0]   = (k % 7 == 0);
                tm_mode[1]  = 2'((m + 1) % 4);
                tm_up[1]    = 1'(1 - u);
                tm_mie[1]   = 1'(pe);
                tm_pm_en[1] = 1'(mi);
                tm_cnt[1]   = 4'(15 - c);
                tm_pre[1]   = 2'(p);
                tm_cap[1]   = 1'(k >> 1);
                tm_dma[1]   = (k % 5 == 0);
                clr_we      = 1'b1;
                clr_mask    = 32'hFFFF_FFFF;
                e = exp_set(0, 4, tm_mode[0], tm_up[0], tm_mie[0], tm_pm_en[0], tm_cnt[0],
                            tm_pre[0], tm_match[0], tm_pmatch[0], tm_load[0], tm_cap[0], tm_dma[0])
                  | exp_set(8, 11, tm_mode[1], tm_up[1], tm_mie[1], tm_pm_en[1], tm_cnt[1],
                            tm_pre[1], tm_match[1], tm_pmatch[1], tm_load[1], tm_cap[1], tm_dma[1]);
                cyc();
                // R2 R3 R4 R5 R6 R7 R8 R9 R11 covered by exact set compare
                chk(ris == e, "R2-sweep R3 R4 R5 R6 R7 R8 R9 R11", ris, e);
                chk(ris_any == (e != 0), "R13", {31'h0, ris_any}, {31'h0, e != 0});
                chk((ris & ~32'h0000_2F37) == 0, "R12", ris, ris & 32'h0000_2F37);
                k++;
              end

    // directed: clear everything with events idle
    @(negedge clk);
    idle_inputs();
    clr_we = 1'b1; clr_mask = 32'hFFFF_FFFF;
    cyc();
    chk(ris == 32'h0, "R10", ris, 32'h0);

    // R10: sticky after a one-cycle DMA pulse
    @(negedge clk);
    idle_inputs();
    tm_dma = 2'b01;
    cyc();
    @(negedge clk);
    tm_dma = 2'b00;
    cyc(); cyc(); cyc();
    chk(ris == 32'h20 && ris_any, "R10", ris, 32'h20);

    // R10: zero in the mask leaves the bit untouched
    @(negedge clk);
    clr_we = 1'b1; clr_mask = 32'hFFFF_FFDF;
    cyc();
    chk(ris == 32'h20, "R10", ris, 32'h20);

    // R10: one in the mask clears it
    @(negedge clk);
    clr_mask = 32'h0000_0020;
    cyc();
    chk(ris == 32'h0 && !ris_any, "R10", ris, 32'h0);

    // R11: simultaneous set and clear on Timer B DMA bit
    @(negedge clk);
    tm_dma = 2'b10; clr_mask = 32'h0000_2000;
    cyc();
    chk(ris == 32'h2000, "R11", ris, 32'h2000);

    // R7: capture pulse outside edge-time mode leaves bits clear
    @(negedge clk);
    idle_inputs();
    clr_we = 1'b1; clr_mask = 32'hFFFF_FFFF;
    cyc();
    @(negedge clk);
    idle_inputs();
    tm_cap = 2'b11; tm_mode = {2'd0, 2'd1};
    tm_cnt = {4'd3, 4'd3}; tm_up = 2'b00;
    cyc();
    chk(ris == 32'h0, "R7", ris, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule